// File: doc/BRIEF.md
# Incremental Halted Cache Dump Controller

This controller sits beside a cache and a debug output port. While the processor runs, it watches the cache write strobe and keeps one history bit for each group of consecutive cache lines. That group is called a window, and its size is set by a parameter. A write to any line of a window marks that window as touched. When a debug flow asks for a snapshot, the controller holds the processor halted. It then walks the history table and streams out only the windows that were touched since the previous snapshot, one line per beat, over a valid/ready stream. Untouched windows cost one search cycle at most. Runs of untouched windows are skipped together in that one cycle.

Line contents are fetched through a read port with a one-cycle latency. Each fetched line is presented on the output together with its line index. Each selected window is sent whole, including lines that were never written. A window's history bit is cleared at the moment the scan selects that window. When the scan ends, the table therefore holds only writes that the scan could no longer include. A one-cycle completion pulse closes every snapshot, including a snapshot that finds nothing to send.

Top module: `icd_dump_ctrl`

## Requirements
- R1: A snapshot request (dump_req high at a clock edge) is accepted only while halt is low. halt goes high in the cycle after acceptance, stays high up to and including the done cycle, and is low in the cycle after done. rd_en and out_valid are asserted only while halt is high.
- R2: A cache write (wr_en high at a clock edge) to line L sets the history bit of window L / WIN, where WIN is the number of lines per history bit (parameter, 1 to 16). No other history bit is changed by that write.
- R3: A snapshot sends lines only from windows whose history bit is set. Windows whose bit is clear produce no beat.
- R4: For every selected window w, all WIN lines w*WIN to w*WIN+WIN-1 are sent, including lines that were not written.
- R5: Selected windows are sent in ascending window index, and the lines within each window in ascending line index. out_idx carries the line index of the beat, so line indices strictly increase within one snapshot.
- R6: out_data equals the cache content of line out_idx. The content is read with rd_en and rd_idx and returned on rd_data in the cycle after rd_en.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_idx and out_data hold their values into the next cycle.
- R8: done is high for exactly one cycle, after the last beat has been accepted. If no history bit is set, done follows acceptance without any beat.
- R9: After a snapshot, a second snapshot with no cache write in between sends no beat.
- R10: A request made while a snapshot is in progress is ignored. No second snapshot starts after done.
- R11: A write during a snapshot to a window above the window being sent is included in the same snapshot. A write to a window that the scan has already selected is kept for the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Cache write strobe |
| wr_idx | input | $clog2(LINES) | Line index of the cache write |
| dump_req | input | 1 | Snapshot start request |
| halt | output | 1 | Processor hold during a snapshot |
| done | output | 1 | One-cycle snapshot completion pulse |
| rd_en | output | 1 | Cache line read strobe |
| rd_idx | output | $clog2(LINES) | Line index to read |
| rd_data | input | DATA_W | Line content, valid the cycle after rd_en |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted by the port |
| out_idx | output | $clog2(LINES) | Line index of the output beat |
| out_data | output | DATA_W | Line content of the output beat |

## Verification
The bench targets four corner cases.

- **Empty table.** A controller that relied on sending a beat before finishing would hang or fail to pulse done.
- **Lowest and highest windows.** An off-by-one in the scan bound would drop line 0 or the top line, or would walk past the end of the table.
- **Writes during a snapshot.** If the bit were cleared at the end instead of at selection, the deferred write would be lost. If already-passed windows were revisited, the same lines would be emitted twice.
- **Backpressure and requests during a snapshot.** Pseudo-random stalls expose a beat that changes under backpressure. A request made mid-snapshot would start a spurious second dump if the request were not ignored while busy.

// File: rtl/icd_pkg.sv
package icd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIND,
      ST_READ,
      ST_CAPT,
      ST_SEND,
      ST_FINISH
   } icd_state_e;

   function automatic bit icd_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int icd_bits(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/icd_win_map.sv
module icd_win_map #(
   parameter int LINES = 64,
   parameter int WIN   = 4,
   localparam int IDX_W  = icd_pkg::icd_bits(LINES),
   localparam int WIDX_W = icd_pkg::icd_bits(LINES / WIN),
   localparam int OFF_W  = icd_pkg::icd_bits(WIN)
) (
   input  logic [IDX_W-1:0]  line_idx,
   output logic [WIDX_W-1:0] win_idx
);

   generate
      if (WIN == 1) begin : g_unit
         assign win_idx = WIDX_W'(line_idx);
      end else if (icd_pkg::icd_is_pow2(WIN)) begin : g_shift
         assign win_idx = WIDX_W'(line_idx >> OFF_W);
      end else begin : g_div
         assign win_idx = WIDX_W'(line_idx / IDX_W'(WIN));
      end
   endgenerate

endmodule

// File: rtl/icd_hist_table.sv
module icd_hist_table #(
   parameter int NWIN = 16,
   localparam int WIDX_W = icd_pkg::icd_bits(NWIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [WIDX_W-1:0] set_win,
   input  logic              clr_en,
   input  logic [WIDX_W-1:0] clr_win,
   output logic [NWIN-1:0]   bits
);

   genvar gi;
   generate
      for (gi = 0; gi < NWIN; gi++) begin : g_bit
         logic hit_set;
         logic hit_clr;
         assign hit_set = set_en && (int'(set_win) == gi);
         assign hit_clr = clr_en && (int'(clr_win) == gi);
         always_ff @(posedge clk) begin
            if (!rst_n)       bits[gi] <= 1'b0;
            else if (hit_set) bits[gi] <= 1'b1;
            else if (hit_clr) bits[gi] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/icd_next_win.sv
module icd_next_win #(
   parameter int NWIN = 16,
   localparam int WIDX_W = icd_pkg::icd_bits(NWIN)
) (
   input  logic [NWIN-1:0]   bits,
   input  logic [WIDX_W-1:0] base,
   output logic              found,
   output logic [WIDX_W-1:0] win
);

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int i = NWIN - 1; i >= 0; i--) begin
         if (bits[i] && (i >= int'(base))) begin
            found = 1'b1;
            win   = WIDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/icd_scan_fsm.sv
module icd_scan_fsm
   import icd_pkg::*;
#(
   parameter int LINES  = 64,
   parameter int WIN    = 4,
   parameter int DATA_W = 32,
   localparam int NWIN   = LINES / WIN,
   localparam int IDX_W  = icd_bits(LINES),
   localparam int WIDX_W = icd_bits(NWIN),
   localparam int OFF_W  = icd_bits(WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dump_req,
   input  logic              found,
   input  logic [WIDX_W-1:0] found_win,
   output logic [WIDX_W-1:0] base_win,
   output logic              clr_en,
   output logic [WIDX_W-1:0] clr_win,
   output logic              halt,
   output logic              done,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_data
);

   localparam logic [OFF_W-1:0]  OFF_LAST = OFF_W'(WIN - 1);
   localparam logic [WIDX_W-1:0] WIN_LAST = WIDX_W'(NWIN - 1);

   icd_state_e        state_q;
   logic [WIDX_W-1:0] win_q;
   logic [OFF_W-1:0]  off_q;
   logic [IDX_W-1:0]  line_q;
   logic [DATA_W-1:0] data_q;
   logic [IDX_W-1:0]  cur_line;

   assign cur_line  = IDX_W'(IDX_W'(win_q) * IDX_W'(WIN)) + IDX_W'(off_q);

   assign base_win  = win_q;
   assign clr_en    = (state_q == ST_FIND) && found;
   assign clr_win   = found_win;
   assign halt      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_FINISH);
   assign rd_en     = (state_q == ST_READ);
   assign rd_idx    = cur_line;
   assign out_valid = (state_q == ST_SEND);
   assign out_idx   = line_q;
   assign out_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         win_q   <= '0;
         off_q   <= '0;
         line_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (dump_req) begin
                  win_q   <= '0;
                  off_q   <= '0;
                  state_q <= ST_FIND;
               end
            end
            ST_FIND: begin
               if (found) begin
                  win_q   <= found_win;
                  off_q   <= '0;
                  state_q <= ST_READ;
               end else begin
                  state_q <= ST_FINISH;
               end
            end
            ST_READ: state_q <= ST_CAPT;
            ST_CAPT: begin
               data_q  <= rd_data;
               line_q  <= cur_line;
               state_q <= ST_SEND;
            end
            ST_SEND: begin
               if (out_ready) begin
                  if (off_q != OFF_LAST) begin
                     off_q   <= off_q + 1'b1;
                     state_q <= ST_READ;
                  end else if (win_q == WIN_LAST) begin
                     state_q <= ST_FINISH;
                  end else begin
                     win_q   <= win_q + 1'b1;
                     state_q <= ST_FIND;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/icd_dump_ctrl.sv
module icd_dump_ctrl #(
   parameter int LINES  = 64,
   parameter int WIN    = 4,
   parameter int DATA_W = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [icd_pkg::icd_bits(LINES)-1:0]   wr_idx,
   input  logic                                  dump_req,
   output logic                                  halt,
   output logic                                  done,
   output logic                                  rd_en,
   output logic [icd_pkg::icd_bits(LINES)-1:0]   rd_idx,
   input  logic [DATA_W-1:0]                     rd_data,
   output logic                                  out_valid,
   input  logic                                  out_ready,
   output logic [icd_pkg::icd_bits(LINES)-1:0]   out_idx,
   output logic [DATA_W-1:0]                     out_data
);

   localparam int NWIN   = LINES / WIN;
   localparam int WIDX_W = icd_pkg::icd_bits(NWIN);

   generate
      if (WIN < 1 || WIN > 16) begin : g_bad_win
         $error("icd_dump_ctrl: WIN must lie in 1..16");
      end
      if (LINES < WIN || (LINES % WIN) != 0) begin : g_bad_lines
         $error("icd_dump_ctrl: LINES must be a positive multiple of WIN");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("icd_dump_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic [WIDX_W-1:0] wr_win;
   logic              set_en;
   logic [NWIN-1:0]   hist_bits;
   logic              clr_en;
   logic [WIDX_W-1:0] clr_win;
   logic [WIDX_W-1:0] base_win;
   logic              found;
   logic [WIDX_W-1:0] found_win;

   assign set_en = wr_en && (int'(wr_idx) < LINES);

   icd_win_map #(.LINES(LINES), .WIN(WIN)) u_map (
      .line_idx (wr_idx),
      .win_idx  (wr_win)
   );

   icd_hist_table #(.NWIN(NWIN)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_en),
      .set_win (wr_win),
      .clr_en  (clr_en),
      .clr_win (clr_win),
      .bits    (hist_bits)
   );

   icd_next_win #(.NWIN(NWIN)) u_find (
      .bits  (hist_bits),
      .base  (base_win),
      .found (found),
      .win   (found_win)
   );

   icd_scan_fsm #(.LINES(LINES), .WIN(WIN), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .dump_req  (dump_req),
      .found     (found),
      .found_win (found_win),
      .base_win  (base_win),
      .clr_en    (clr_en),
      .clr_win   (clr_win),
      .halt      (halt),
      .done      (done),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_idx   (out_idx),
      .out_data  (out_data)
   );

endmodule

// File: rtl/icd_dump_ctrl_chk.sv
module icd_dump_ctrl_chk #(
   parameter int LINES  = 64,
   parameter int WIN    = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = icd_pkg::icd_bits(LINES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dump_req,
   input logic              halt,
   input logic              done,
   input logic              rd_en,
   input logic              out_valid,
   input logic              out_ready,
   input logic [IDX_W-1:0]  out_idx,
   input logic [DATA_W-1:0] out_data
);

   logic             seen_q;
   logic [IDX_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n || done) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (out_valid && out_ready) begin
         seen_q <= 1'b1;
         last_q <= out_idx;
      end
   end

   p_halt_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && dump_req) |=> halt);

   p_halt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !done) |=> halt);

   p_active_in_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || out_valid) |-> halt);

   p_line_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_idx) < LINES));

   p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && seen_q) |-> (out_idx > last_q));

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_data)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !halt));

endmodule

bind icd_dump_ctrl icd_dump_ctrl_chk #(
   .LINES(LINES), .WIN(WIN), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dump_req  (dump_req),
   .halt      (halt),
   .done      (done),
   .rd_en     (rd_en),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_idx   (out_idx),
   .out_data  (out_data)
);

// File: tb/sim_icd_dump_ctrl.sv
module sim_icd_dump_ctrl;

   localparam int LINES  = 64;
   localparam int WIN    = 4;
   localparam int DATA_W = 32;
   localparam int NWIN   = LINES / WIN;
   localparam int IDX_W  = $clog2(LINES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              wr_en = 1'b0;
   logic [IDX_W-1:0]  wr_idx = '0;
   logic              dump_req = 1'b0;
   logic              halt, done, rd_en, out_valid;
   logic [IDX_W-1:0]  rd_idx, out_idx;
   logic [DATA_W-1:0] rd_data = '0;
   logic [DATA_W-1:0] out_data;
   logic              out_ready;
   logic              bp_mode = 1'b0;
   logic [15:0]       lfsr = 16'hACE1;

   icd_dump_ctrl #(.LINES(LINES), .WIN(WIN), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .dump_req(dump_req), .halt(halt), .done(done), .rd_en(rd_en),
      .rd_idx(rd_idx), .rd_data(rd_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_idx(out_idx), .out_data(out_data)
   );

   // cache storage model with one-cycle read latency
   logic [DATA_W-1:0] mem [LINES];
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_idx];

   always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   assign out_ready = bp_mode ? lfsr[0] : 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model, evaluated every cycle
   bit                mhist [NWIN];
   bit                mbusy = 0;
   int                mlast, mcur, moff;
   int                beats = 0;
   int                last_beats = 0;
   int                dumps_done = 0;
   bit                hold_prev = 0;
   logic [IDX_W-1:0]  prev_idx;
   logic [DATA_W-1:0] prev_data;

   function automatic int next_set(input int after);
      for (int w = after + 1; w < NWIN; w++) if (mhist[w]) return w;
      return -1;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         bit busy_now;
         busy_now = mbusy;
         chk(halt === busy_now, "R1", "halt", halt, busy_now);
         if (rd_en && !halt) chk(0, "R1", "rd_en outside halt", rd_en, 0);
         if (out_valid && !halt) chk(0, "R1", "out_valid outside halt", out_valid, 0);
         if (hold_prev) begin
            chk(out_valid === 1'b1, "R7", "valid held", out_valid, 1);
            chk(out_idx === prev_idx, "R7", "idx held", out_idx, prev_idx);
            chk(out_data === prev_data, "R7", "data held", out_data, prev_data);
         end
         hold_prev = out_valid && !out_ready;
         prev_idx  = out_idx;
         prev_data = out_data;
         if (out_valid && out_ready) begin
            if (moff == 0) begin
               mcur = next_set(mlast);
               chk(mcur >= 0, "R3", "beat from unselected window", out_idx, -1);
               if (mcur >= 0) mhist[mcur] = 0;
            end
            chk(int'(out_idx) == mcur * WIN + moff, "R5", "line index", out_idx, mcur * WIN + moff);
            chk(out_data === mem[out_idx], "R6", "line data", out_data, mem[out_idx]);
            beats++;
            moff++;
            if (moff == WIN) begin
               moff  = 0;
               mlast = mcur;
            end
         end
         if (done) begin
            chk(busy_now, "R8", "done outside dump", done, 0);
            chk(moff == 0, "R4", "window cut short", moff, 0);
            chk(next_set(mlast) < 0, "R3", "selected window missing", next_set(mlast), -1);
            mbusy = 0;
            last_beats = beats;
            dumps_done++;
         end
         if (wr_en) mhist[int'(wr_idx) / WIN] = 1;
         if (dump_req && !busy_now) begin
            mbusy = 1;
            mlast = -1;
            moff  = 0;
            beats = 0;
         end
      end
   end

   task automatic do_write(input int idx, input logic [DATA_W-1:0] val);
      @(posedge clk); #1;
      wr_en  = 1'b1;
      wr_idx = IDX_W'(idx);
      mem[idx] = val;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic run_dump(output int nb);
      int d0, t;
      d0 = dumps_done;
      t = 0;
      @(posedge clk); #1 dump_req = 1'b1;
      @(posedge clk); #1 dump_req = 1'b0;
      while (dumps_done == d0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(dumps_done != d0, "R8", "done never seen", 0, 1);
      nb = last_beats;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int nb;
      for (int i = 0; i < LINES; i++) mem[i] = 32'h1000_0000 + 32'(i * 7);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(halt === 1'b0, "R1", "reset halt", halt, 0);
      chk(out_valid === 1'b0, "R1", "reset out_valid", out_valid, 0);
      chk(done === 1'b0, "R8", "reset done", done, 0);
      chk(rd_en === 1'b0, "R1", "reset rd_en", rd_en, 0);

      // R8: empty table finishes without beats
      run_dump(nb);
      chk(nb == 0, "R8", "beats on empty table", nb, 0);

      // R2 R4: one write selects a full window
      do_write(5, 32'hDEAD_0005);
      run_dump(nb);
      chk(nb == WIN, "R4", "beats for one window", nb, WIN);

      // R3 R5: scattered windows including both ends, two writes in one window
      do_write(63, 32'hAAAA_003F);
      do_write(13, 32'hAAAA_000D);
      do_write(0, 32'hAAAA_0000);
      do_write(14, 32'hAAAA_000E);
      run_dump(nb);
      chk(nb == 3 * WIN, "R2", "beats for three windows", nb, 3 * WIN);

      // R9: table empty after a dump
      run_dump(nb);
      chk(nb == 0, "R9", "beats after clear", nb, 0);

      // R7: backpressure
      bp_mode = 1'b1;
      do_write(20, 32'h5555_0014);
      do_write(40, 32'h5555_0028);
      do_write(41, 32'h5555_0029);
      do_write(59, 32'h5555_003B);
      run_dump(nb);
      chk(nb == 3 * WIN, "R7", "beats under backpressure", nb, 3 * WIN);
      bp_mode = 1'b0;

      // R10: request during a dump is ignored
      do_write(30, 32'h7777_001E);
      fork
         run_dump(nb);
         begin
            repeat (6) @(posedge clk);
            #1 dump_req = 1'b1;
            @(posedge clk); #1 dump_req = 1'b0;
         end
      join
      chk(nb == WIN, "R10", "beats in busy-request dump", nb, WIN);
      repeat (5) @(negedge clk);
      chk(halt === 1'b0, "R10", "second dump started", halt, 0);

      // R11: writes during a dump
      do_write(4, 32'h9999_0004);
      fork
         run_dump(nb);
         begin
            repeat (4) @(posedge clk);
            do_write(62, 32'h9999_003E);
            do_write(2, 32'h9999_0002);
         end
      join
      chk(nb == 2 * WIN, "R11", "write ahead included", nb, 2 * WIN);
      run_dump(nb);
      chk(nb == WIN, "R11", "write behind deferred", nb, WIN);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule